// File: doc/BRIEF.md
# DMA Block Merge Buffer

This block stages cache-block-sized DMA transactions between an I/O bridge and main memory. A transaction is opened by an allocation that states whether it is a read or a write and whether the block hit in the external cache. Each open transaction owns a slot with three block-wide areas: one for write data with its byte enables, one for the main-memory copy and one for the cache copy. Each area is filled through its own valid/ready load port, and each load names the slot it targets.

For a read, the block returns the cache copy on a hit and the memory copy on a miss. For a write, it overlays the enabled bytes of the write data on the current copy of the block, which is the cache copy on a hit and the memory copy otherwise. The result is the block to write back to memory. Several transactions may be open at once. Slots are handed out in rotation, and results leave in allocation order through a valid/ready output port. The slot is freed when the output handshake completes.

Top module: `dma_merge_buf`

## Requirements
- R1: While reset is asserted and on the first cycle after it, outValid, loadErr and all three load ready signals are low, allocReady is high and allocSlot is 0.
- R2: allocSlot starts at 0 and advances by one, wrapping at NUM_SLOTS, for each accepted allocation (allocValid and allocReady high). allocReady is low exactly when all NUM_SLOTS slots are held.
- R3: A load port's ready is high exactly when the slot it names is held. A load to a free slot is not accepted and has no effect.
- R4: outValid rises in the cycle after the last area a transaction needs has been loaded. The memory area is always needed, the cache area is needed when allocHit was 1, and the write area is needed when allocWrite was 1.
- R5: For a read (outWrite 0), outData equals the loaded cache data when the hit flag was set and the loaded memory data otherwise.
- R6: For a write (outWrite 1), byte i of outData (bits 8i+7 down to 8i) is byte i of the write data when bit i of its byte enable is 1. Otherwise it is byte i of the merge source, which is the cache area on a hit and the memory area on a miss.
- R7: An accepted load into an area that is already loaded, or into an area the transaction does not use, is discarded: the area keeps its first contents. loadErr is high for exactly the following cycle.
- R8: Results are presented in allocation order on outSlot. While outValid is high and outReady low, outValid, outSlot and outData hold steady. The head slot is freed on the handshake.
- R9: Two transactions can be open at once. A later transaction that completes first does not overtake an earlier one that is still incomplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allocValid | input | 1 | Request to open a transaction |
| allocWrite | input | 1 | 1 = DMA write, 0 = DMA read |
| allocHit | input | 1 | Block hit in the external cache |
| allocReady | output | 1 | A free slot is available |
| allocSlot | output | SLOT_W | Slot the next allocation receives |
| wrValid | input | 1 | Write-data load valid |
| wrSlot | input | SLOT_W | Target slot of the write-data load |
| wrData | input | BLOCK_BYTES*8 | Write data block |
| wrByteEn | input | BLOCK_BYTES | Byte enables of the write data |
| wrReady | output | 1 | Write-data load accepted |
| memValid | input | 1 | Memory-data load valid |
| memSlot | input | SLOT_W | Target slot of the memory load |
| memData | input | BLOCK_BYTES*8 | Memory copy of the block |
| memReady | output | 1 | Memory load accepted |
| cacheValid | input | 1 | Cache-data load valid |
| cacheSlot | input | SLOT_W | Target slot of the cache load |
| cacheData | input | BLOCK_BYTES*8 | Cache copy of the block |
| cacheReady | output | 1 | Cache load accepted |
| outValid | output | 1 | Result block available |
| outReady | input | 1 | Consumer takes the result |
| outSlot | output | SLOT_W | Slot of the presented result |
| outWrite | output | 1 | Presented result is a write-back block |
| outData | output | BLOCK_BYTES*8 | Read data or merged block |
| loadErr | output | 1 | Previous cycle accepted a discarded load |

## Verification
The assertions assume that outReady is only meaningful while outValid is high and that slot numbers on the load ports lie below NUM_SLOTS. The bench keeps slot fields one bit wide with two slots, so every value is in range. It drives random outReady, and the reference model releases a result only on a cycle where both handshake signals are high. Allocation requests, including ones made while all slots are held, and loads to free, unused or already-filled areas are sent on purpose. This covers the refusal and error paths.

// File: rtl/dmb_pkg.sv
package dmb_pkg;

  // Operation recorded for a slot at allocation time
  typedef struct packed {
    logic isWrite;
    logic hit;
  } dmbOpT;

  // Per-slot capture strobes from control to datapath
  typedef struct packed {
    logic ldWr;
    logic ldMem;
    logic ldCache;
  } dmbStbT;

endpackage

// File: rtl/dmb_ctrl.sv
module dmb_ctrl
  import dmb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned CNT_W  = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  dmbOpT             allocOp,
  output logic              allocReady,
  output logic [SLOT_W-1:0] allocSlot,
  input  logic              wrValid,
  input  logic [SLOT_W-1:0] wrSlot,
  output logic              wrReady,
  input  logic              memValid,
  input  logic [SLOT_W-1:0] memSlot,
  output logic              memReady,
  input  logic              cacheValid,
  input  logic [SLOT_W-1:0] cacheSlot,
  output logic              cacheReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [SLOT_W-1:0] outSlot,
  output dmbOpT             outOp,
  output logic              loadErr,
  output dmbStbT            stb [NUM_SLOTS]
);

  logic [NUM_SLOTS-1:0] busy;
  logic [NUM_SLOTS-1:0] gotWr, gotMem, gotCache;
  logic [NUM_SLOTS-1:0] goodWr, goodMem, goodCache;
  logic [NUM_SLOTS-1:0] complete;
  dmbOpT                op [NUM_SLOTS];
  logic [SLOT_W-1:0]    headPtr, tailPtr;
  logic [CNT_W-1:0]     heldCnt;
  logic                 allocFire, outFire;
  logic                 wrFire, memFire, cacheFire;
  logic                 anyErr;

  function automatic logic pickBit(input logic [NUM_SLOTS-1:0] vec,
                                   input logic [SLOT_W-1:0] idx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (idx == SLOT_W'(i)) r = vec[i];
    end
    return r;
  endfunction

  function automatic logic [SLOT_W-1:0] nextPtr(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(NUM_SLOTS - 1)) ? '0 : p + SLOT_W'(1);
  endfunction

  assign allocReady = (heldCnt != CNT_W'(NUM_SLOTS));
  assign allocSlot  = tailPtr;
  assign allocFire  = allocValid && allocReady;

  assign wrReady    = pickBit(busy, wrSlot);
  assign memReady   = pickBit(busy, memSlot);
  assign cacheReady = pickBit(busy, cacheSlot);
  assign wrFire     = wrValid && wrReady;
  assign memFire    = memValid && memReady;
  assign cacheFire  = cacheValid && cacheReady;

  assign outValid = pickBit(complete, headPtr);
  assign outSlot  = headPtr;
  assign outOp    = op[headPtr];
  assign outFire  = outValid && outReady;

  // Slot state repeats once per slot
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic wrSel, memSel, cacheSel;
    logic allocHere, relHere;

    assign wrSel    = wrFire    && (wrSlot    == SLOT_W'(s));
    assign memSel   = memFire   && (memSlot   == SLOT_W'(s));
    assign cacheSel = cacheFire && (cacheSlot == SLOT_W'(s));

    assign goodWr[s]    = wrSel    && op[s].isWrite && !gotWr[s];
    assign goodMem[s]   = memSel   && !gotMem[s];
    assign goodCache[s] = cacheSel && op[s].hit && !gotCache[s];

    assign allocHere = allocFire && (tailPtr == SLOT_W'(s));
    assign relHere   = outFire   && (headPtr == SLOT_W'(s));

    assign complete[s] = busy[s] && gotMem[s]
                       && (gotWr[s] || !op[s].isWrite)
                       && (gotCache[s] || !op[s].hit);

    assign stb[s] = '{ldWr: goodWr[s], ldMem: goodMem[s], ldCache: goodCache[s]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busy[s]     <= 1'b0;
        op[s]       <= '0;
        gotWr[s]    <= 1'b0;
        gotMem[s]   <= 1'b0;
        gotCache[s] <= 1'b0;
      end else if (relHere) begin
        busy[s]     <= 1'b0;
        gotWr[s]    <= 1'b0;
        gotMem[s]   <= 1'b0;
        gotCache[s] <= 1'b0;
      end else if (allocHere) begin
        busy[s]     <= 1'b1;
        op[s]       <= allocOp;
        gotWr[s]    <= 1'b0;
        gotMem[s]   <= 1'b0;
        gotCache[s] <= 1'b0;
      end else begin
        if (goodWr[s])    gotWr[s]    <= 1'b1;
        if (goodMem[s])   gotMem[s]   <= 1'b1;
        if (goodCache[s]) gotCache[s] <= 1'b1;
      end
    end
  end

  assign anyErr = (wrFire && !(|goodWr))
               || (memFire && !(|goodMem))
               || (cacheFire && !(|goodCache));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      heldCnt <= '0;
      loadErr <= 1'b0;
    end else begin
      loadErr <= anyErr;
      if (allocFire) tailPtr <= nextPtr(tailPtr);
      if (outFire)   headPtr <= nextPtr(headPtr);
      case ({allocFire, outFire})
        2'b10:   heldCnt <= heldCnt + CNT_W'(1);
        2'b01:   heldCnt <= heldCnt - CNT_W'(1);
        default: heldCnt <= heldCnt;
      endcase
    end
  end

endmodule

// File: rtl/dmb_datapath.sv
module dmb_datapath
  import dmb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 2,
  parameter int unsigned BLOCK_BYTES = 64,
  localparam int unsigned DATA_W = BLOCK_BYTES * 8,
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                   clk,
  input  dmbStbT                 stb [NUM_SLOTS],
  input  logic [DATA_W-1:0]      wrData,
  input  logic [BLOCK_BYTES-1:0] wrByteEn,
  input  logic [DATA_W-1:0]      memData,
  input  logic [DATA_W-1:0]      cacheData,
  input  logic [SLOT_W-1:0]      outSlot,
  input  dmbOpT                  outOp,
  output logic [DATA_W-1:0]      outData
);

  logic [DATA_W-1:0]      wrQ    [NUM_SLOTS];
  logic [BLOCK_BYTES-1:0] beQ    [NUM_SLOTS];
  logic [DATA_W-1:0]      memQ   [NUM_SLOTS];
  logic [DATA_W-1:0]      cacheQ [NUM_SLOTS];

  // Three block-wide areas per slot
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_store
    always_ff @(posedge clk) begin
      if (stb[s].ldWr) begin
        wrQ[s] <= wrData;
        beQ[s] <= wrByteEn;
      end
      if (stb[s].ldMem)   memQ[s]   <= memData;
      if (stb[s].ldCache) cacheQ[s] <= cacheData;
    end
  end

  logic [DATA_W-1:0]      selWr, selSrc;
  logic [BLOCK_BYTES-1:0] selBe;

  assign selWr  = wrQ[outSlot];
  assign selBe  = beQ[outSlot];
  assign selSrc = outOp.hit ? cacheQ[outSlot] : memQ[outSlot];

  // Byte lane overlay for writes; reads pass the source through
  for (genvar b = 0; b < BLOCK_BYTES; b++) begin : g_lane
    assign outData[8*b +: 8] = (outOp.isWrite && selBe[b]) ? selWr[8*b +: 8]
                                                            : selSrc[8*b +: 8];
  end

endmodule

// File: rtl/dma_merge_buf.sv
module dma_merge_buf
  import dmb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 2,
  parameter int unsigned BLOCK_BYTES = 64,
  localparam int unsigned DATA_W = BLOCK_BYTES * 8,
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   allocValid,
  input  logic                   allocWrite,
  input  logic                   allocHit,
  output logic                   allocReady,
  output logic [SLOT_W-1:0]      allocSlot,
  input  logic                   wrValid,
  input  logic [SLOT_W-1:0]      wrSlot,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [BLOCK_BYTES-1:0] wrByteEn,
  output logic                   wrReady,
  input  logic                   memValid,
  input  logic [SLOT_W-1:0]      memSlot,
  input  logic [DATA_W-1:0]      memData,
  output logic                   memReady,
  input  logic                   cacheValid,
  input  logic [SLOT_W-1:0]      cacheSlot,
  input  logic [DATA_W-1:0]      cacheData,
  output logic                   cacheReady,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [SLOT_W-1:0]      outSlot,
  output logic                   outWrite,
  output logic [DATA_W-1:0]      outData,
  output logic                   loadErr
);

  dmbOpT  allocOp, outOp;
  dmbStbT stb [NUM_SLOTS];

  assign allocOp  = '{isWrite: allocWrite, hit: allocHit};
  assign outWrite = outOp.isWrite;

  dmb_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allocValid (allocValid),
    .allocOp    (allocOp),
    .allocReady (allocReady),
    .allocSlot  (allocSlot),
    .wrValid    (wrValid),
    .wrSlot     (wrSlot),
    .wrReady    (wrReady),
    .memValid   (memValid),
    .memSlot    (memSlot),
    .memReady   (memReady),
    .cacheValid (cacheValid),
    .cacheSlot  (cacheSlot),
    .cacheReady (cacheReady),
    .outValid   (outValid),
    .outReady   (outReady),
    .outSlot    (outSlot),
    .outOp      (outOp),
    .loadErr    (loadErr),
    .stb        (stb)
  );

  dmb_datapath #(.NUM_SLOTS(NUM_SLOTS), .BLOCK_BYTES(BLOCK_BYTES)) u_dp (
    .clk       (clk),
    .stb       (stb),
    .wrData    (wrData),
    .wrByteEn  (wrByteEn),
    .memData   (memData),
    .cacheData (cacheData),
    .outSlot   (outSlot),
    .outOp     (outOp),
    .outData   (outData)
  );

endmodule

// File: rtl/dma_merge_buf_chk.sv
module dma_merge_buf_chk #(
  parameter int unsigned NUM_SLOTS   = 2,
  parameter int unsigned BLOCK_BYTES = 64,
  localparam int unsigned DATA_W = BLOCK_BYTES * 8,
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned CNT_W  = $clog2(NUM_SLOTS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              allocValid,
  input logic              allocReady,
  input logic [SLOT_W-1:0] allocSlot,
  input logic              wrValid,
  input logic [SLOT_W-1:0] wrSlot,
  input logic              wrReady,
  input logic              memValid,
  input logic [SLOT_W-1:0] memSlot,
  input logic              memReady,
  input logic              cacheValid,
  input logic [SLOT_W-1:0] cacheSlot,
  input logic              cacheReady,
  input logic              outValid,
  input logic              outReady,
  input logic [SLOT_W-1:0] outSlot,
  input logic [DATA_W-1:0] outData,
  input logic              loadErr
);

  logic [NUM_SLOTS-1:0] held, memSeen;
  logic [SLOT_W-1:0]    aPtr, rPtr;
  logic [CNT_W-1:0]     cnt;
  logic                 aFire, rFire;

  function automatic logic pick(input logic [NUM_SLOTS-1:0] v, input logic [SLOT_W-1:0] i);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NUM_SLOTS; k++) if (i == SLOT_W'(k)) r = v[k];
    return r;
  endfunction

  function automatic logic [SLOT_W-1:0] adv(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(NUM_SLOTS - 1)) ? '0 : p + SLOT_W'(1);
  endfunction

  assign aFire = allocValid && allocReady;
  assign rFire = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held <= '0; memSeen <= '0; aPtr <= '0; rPtr <= '0; cnt <= '0;
    end else begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
        if (rFire && rPtr == SLOT_W'(k)) begin
          held[k] <= 1'b0; memSeen[k] <= 1'b0;
        end else if (aFire && aPtr == SLOT_W'(k)) begin
          held[k] <= 1'b1; memSeen[k] <= 1'b0;
        end else if (memValid && memReady && memSlot == SLOT_W'(k)) begin
          memSeen[k] <= 1'b1;
        end
      end
      if (aFire) aPtr <= adv(aPtr);
      if (rFire) rPtr <= adv(rPtr);
      cnt <= cnt + CNT_W'(aFire) - CNT_W'(rFire);
    end
  end

  AST_ALLOC_READY: assert property (@(posedge clk) disable iff (!rstN)
    allocReady == (cnt != CNT_W'(NUM_SLOTS))); // R2
  AST_ALLOC_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    allocSlot == aPtr); // R2
  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (wrReady == pick(held, wrSlot)) && (memReady == pick(held, memSlot))
    && (cacheReady == pick(held, cacheSlot))); // R3
  AST_OUT_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> pick(memSeen, outSlot)); // R4
  AST_OUT_IN_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outSlot == rPtr) && pick(held, outSlot)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outSlot) && $stable(outData)); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    loadErr |-> $past((wrValid && wrReady) || (memValid && memReady)
                      || (cacheValid && cacheReady))); // R7

endmodule

bind dma_merge_buf dma_merge_buf_chk #(.NUM_SLOTS(NUM_SLOTS), .BLOCK_BYTES(BLOCK_BYTES)) u_chk (.*);

// File: tb/dma_merge_buf_bench.sv
module dma_merge_buf_bench;
  localparam int N  = 2;
  localparam int BB = 64;
  localparam int DW = BB * 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 0, allocWrite = 0, allocHit = 0, allocReady;
  logic [0:0] allocSlot, wrSlot = 0, memSlot = 0, cacheSlot = 0, outSlot;
  logic wrValid = 0, memValid = 0, cacheValid = 0, outReady = 1;
  logic [DW-1:0] wrData = '0, memData = '0, cacheData = '0, outData;
  logic [BB-1:0] wrByteEn = '0;
  logic wrReady, memReady, cacheReady, outValid, outWrite, loadErr;

  int total = 0, bad = 0, cyc = 0;
  bit running = 0;

  always #2 clk = ~clk;

  dma_merge_buf u_dma_merge_buf (.*);

  // ---------------- reference model ----------------
  bit mHeld[N], mWr[N], mHit[N], gW[N], gM[N], gC[N];
  logic [DW-1:0] mWd[N], mMd[N], mCd[N];
  logic [BB-1:0] mBe[N];
  int q[$];
  int allocCnt;
  bit mErr;

  function automatic logic [DW-1:0] overlay(logic [DW-1:0] w, logic [BB-1:0] be, logic [DW-1:0] src);
    logic [DW-1:0] r = src;
    for (int b = 0; b < BB; b++) if (be[b]) r[8*b +: 8] = w[8*b +: 8];
    return r;
  endfunction

  function automatic bit mDone(int s);
    return mHeld[s] && gM[s] && (gW[s] || !mWr[s]) && (gC[s] || !mHit[s]);
  endfunction

  function automatic bit mValid();
    return (q.size() > 0) && mDone(q[0]);
  endfunction

  function automatic logic [DW-1:0] mData(int s);
    logic [DW-1:0] src = mHit[s] ? mCd[s] : mMd[s];
    return mWr[s] ? overlay(mWd[s], mBe[s], src) : src;
  endfunction

  always @(posedge clk) begin : model
    bit e, rel;
    int sz, s;
    if (!rstN) begin
      for (int k = 0; k < N; k++) begin mHeld[k] = 0; gW[k] = 0; gM[k] = 0; gC[k] = 0; end
      q.delete(); allocCnt = 0; mErr = 0;
    end else begin
      e = 0; sz = q.size();
      rel = mValid() && outReady;
      if (wrValid && mHeld[wrSlot]) begin
        if (mWr[wrSlot] && !gW[wrSlot]) begin gW[wrSlot] = 1; mWd[wrSlot] = wrData; mBe[wrSlot] = wrByteEn; end
        else e = 1;
      end
      if (memValid && mHeld[memSlot]) begin
        if (!gM[memSlot]) begin gM[memSlot] = 1; mMd[memSlot] = memData; end
        else e = 1;
      end
      if (cacheValid && mHeld[cacheSlot]) begin
        if (mHit[cacheSlot] && !gC[cacheSlot]) begin gC[cacheSlot] = 1; mCd[cacheSlot] = cacheData; end
        else e = 1;
      end
      if (rel) begin s = q.pop_front(); mHeld[s] = 0; end
      if (allocValid && sz < N) begin
        s = allocCnt % N;
        mHeld[s] = 1; mWr[s] = allocWrite; mHit[s] = allocHit;
        gW[s] = 0; gM[s] = 0; gC[s] = 0;
        q.push_back(s); allocCnt++;
      end
      mErr = e;
    end
  end

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (running && rstN) begin
      cyc++;
      chk(outValid === mValid(), "R4 outValid", DW'(outValid), DW'(mValid()));
      if (mValid()) begin
        chk(outSlot === 1'(q[0]), "R8 outSlot", DW'(outSlot), DW'(q[0]));
        chk(outWrite === mWr[q[0]], "R8 outWrite", DW'(outWrite), DW'(mWr[q[0]]));
        chk(outData === mData(q[0]), mWr[q[0]] ? "R6 merged data" : "R5 read data",
            outData, mData(q[0]));
      end
      chk(allocReady === (q.size() < N), "R2 allocReady", DW'(allocReady), DW'(q.size() < N));
      chk(allocSlot === 1'(allocCnt % N), "R2 allocSlot", DW'(allocSlot), DW'(allocCnt % N));
      chk(loadErr === mErr, "R7 loadErr", DW'(loadErr), DW'(mErr));
      chk(wrReady === mHeld[wrSlot] && memReady === mHeld[memSlot] && cacheReady === mHeld[cacheSlot],
          "R3 load ready", DW'({wrReady, memReady, cacheReady}),
          DW'({mHeld[wrSlot], mHeld[memSlot], mHeld[cacheSlot]}));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
    allocValid = 0; wrValid = 0; memValid = 0; cacheValid = 0;
  endtask

  task automatic doAlloc(bit w, bit h, output int s);
    s = int'(allocSlot);
    allocValid = 1; allocWrite = w; allocHit = h; tick();
  endtask

  task automatic ldMem(int s, logic [DW-1:0] d);
    memValid = 1; memSlot = 1'(s); memData = d; tick();
  endtask

  task automatic ldCache(int s, logic [DW-1:0] d);
    cacheValid = 1; cacheSlot = 1'(s); cacheData = d; tick();
  endtask

  task automatic ldWr(int s, logic [DW-1:0] d, logic [BB-1:0] be);
    wrValid = 1; wrSlot = 1'(s); wrData = d; wrByteEn = be; tick();
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int s, s0, s1;
    logic [DW-1:0] dM, dC, dW, dX;
    logic [BB-1:0] be;
    dM = {16{32'h1111_0000}}; dC = {16{32'hCCCC_5555}};
    dW = {16{32'hA5A5_9696}}; dX = {16{32'h7777_EEEE}};

    repeat (3) @(posedge clk); #1;
    // R1: reset state
    chk(!outValid && !loadErr && !wrReady && !memReady && !cacheReady && allocReady && allocSlot == 0,
        "R1 reset", DW'({outValid, loadErr, wrReady, memReady, cacheReady, allocReady, allocSlot}),
        DW'(7'b0000010));
    rstN = 1; running = 1;
    tick();
    chk(!outValid && allocReady && allocSlot == 0, "R1 after reset",
        DW'({outValid, allocReady, allocSlot}), DW'(3'b010));

    // R5: read miss returns memory copy
    doAlloc(0, 0, s); ldMem(s, dM);
    chk(outValid && outData === dM, "R5 read miss", outData, dM);
    tick();
    // R5: read hit returns cache copy
    doAlloc(0, 1, s); ldMem(s, dM); ldCache(s, dC);
    chk(outValid && outData === dC, "R5 read hit", outData, dC);
    tick();
    // R6: write miss merges over memory
    be = 64'h00FF_F0F0_0000_8001;
    doAlloc(1, 0, s); ldWr(s, dW, be);
    chk(!outValid, "R4 waits for memory", DW'(outValid), DW'(0));
    ldMem(s, dM);
    chk(outValid && outData === overlay(dW, be, dM), "R6 write miss", outData, overlay(dW, be, dM));
    tick();
    // R6: write hit merges over cache, memory ignored
    be = 64'hAAAA_5555_FFFF_0000;
    doAlloc(1, 1, s); ldMem(s, dM); ldWr(s, dW, be);
    chk(!outValid, "R4 waits for cache", DW'(outValid), DW'(0));
    ldCache(s, dC);
    chk(outValid && outData === overlay(dW, be, dC), "R6 write hit", outData, overlay(dW, be, dC));
    tick();
    doAlloc(1, 0, s); ldMem(s, dM); ldWr(s, dW, '0);
    chk(outData === dM, "R6 empty enables", outData, dM);
    tick();

    // R7: unused area and repeated load
    outReady = 0;
    doAlloc(0, 0, s); ldCache(s, dC);
    chk(loadErr === 1'b1, "R7 unused area", DW'(loadErr), DW'(1));
    ldMem(s, dM);
    chk(loadErr === 1'b0, "R7 good load", DW'(loadErr), DW'(0));
    ldMem(s, dX);
    chk(loadErr === 1'b1 && outData === dM, "R7 repeated load discarded", outData, dM);
    tick();
    chk(loadErr === 1'b0, "R7 single pulse", DW'(loadErr), DW'(0));
    outReady = 1; tick();

    // R3: load to free slot ignored
    memValid = 1; memSlot = 1'(s); memData = dX; #1;
    chk(memReady === 1'b0, "R3 free slot", DW'(memReady), DW'(0));
    tick();
    chk(loadErr === 1'b0, "R3 no effect", DW'(loadErr), DW'(0));

    // R9 / R8: two open transactions, later completes first
    outReady = 0;
    doAlloc(1, 1, s0); doAlloc(0, 0, s1);
    chk(allocReady === 1'b0, "R2 full", DW'(allocReady), DW'(0));
    ldMem(s1, dX);
    chk(outValid === 1'b0, "R9 no overtaking", DW'(outValid), DW'(0));
    ldWr(s0, dW, {BB{1'b1}}); ldMem(s0, dM); ldCache(s0, dC);
    chk(outValid && outSlot === 1'(s0) && outData === dW, "R8 head first", outData, dW);
    tick(); tick();
    chk(outValid && outSlot === 1'(s0), "R8 hold under backpressure", DW'(outSlot), DW'(s0));
    outReady = 1; tick();
    chk(outValid && outSlot === 1'(s1) && outData === dX, "R9 second result", outData, dX);
    tick();

    // random traffic, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      allocValid = ($urandom % 4) == 0;
      allocWrite = $urandom; allocHit = $urandom;
      wrValid = ($urandom % 3) == 0; wrSlot = 1'($urandom);
      wrData = {16{$urandom}}; wrByteEn = {$urandom, $urandom};
      memValid = ($urandom % 3) == 0; memSlot = 1'($urandom); memData = {16{$urandom}};
      cacheValid = ($urandom % 3) == 0; cacheSlot = 1'($urandom); cacheData = {16{$urandom}};
      outReady = ($urandom % 3) != 0;
      @(posedge clk); #1;
    end
    allocValid = 0; wrValid = 0; memValid = 0; cacheValid = 0;
    tick();
    running = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule